// File: doc/BRIEF.md
# I2C Event Status Register

This block holds the 16-bit status word of an I2C controller that can work as master or as slave. The protocol engine around it reports what happens on the bus through single-cycle strobes: a Start or repeated Start was seen, a Stop was seen, an address matched, a byte arrived, a master transmission began, an acknowledge slot finished, or a collision happened. The CPU side adds three more inputs: a write strobe to the transmit holding register, a read strobe on the receive buffer, and a write-to-clear port for the flags that only software may clear.

Each flag has its own set event and its own clear event. Some flags are cleared by the hardware at protocol events, and others are cleared only by software. Every flag is registered, so it changes on the clock edge that samples its event, and the word is always visible on `status`. Bit serialization, SCL generation and the address comparators are outside this block; they appear here only as event inputs.

Top module: `i2c_event_status`

## Requirements
- R1: After reset every bit of `status` is 0. Bits 13, 12 and 11 always read 0.
- R2: Bit 15 (acknowledge status) loads `ack_nack` on `ev_ack_done`, so 1 means NACK and 0 means ACK. It holds its value otherwise.
- R3: Bit 14 (transmit in progress) is set by `ev_tx_begin` and cleared by `ev_ack_done`. If both occur in the same cycle, the set wins.
- R4: Bit 10 (bus collision) is set by `ev_collision`. It is cleared only by a CPU clear with `clr_data[10]`=0. If both occur in the same cycle, the set wins.
- R5: Bit 9 (general call) is set by `ev_gcall_match` and bit 8 (10-bit address) is set by `ev_addr10_match`. Both are cleared by `ev_stop`, and each set wins over the Stop.
- R6: Bit 7 (write collision) is set when `tx_wr` is asserted while `busy`=1, and a write refused this way leaves bit 0 unchanged. Bit 7 is cleared only by a CPU clear with `clr_data[7]`=0, and the set wins over that clear.
- R7: Bit 6 (receive overflow) is set when `ev_rx_byte` arrives while bit 1 is already 1, and bit 1 then stays 1. Bit 6 is cleared only by a CPU clear with `clr_data[6]`=0, and the set wins over that clear.
- R8: Bit 5 (data/address) is cleared by `ev_addr_match` and set by `ev_rx_byte`. If both occur in the same cycle, the address match wins.
- R9: Bit 4 (Stop seen last) is set by `ev_stop`. Bit 3 (Start seen) is set by `ev_start` or `ev_rstart`. Each of the two is cleared by the other's event. When a Start and a Stop arrive in the same cycle, the Start wins (bit 3 = 1, bit 4 = 0).
- R10: Bit 2 (read/write direction) loads `rw_in` on `ev_addr_match` and holds its value otherwise.
- R11: Bit 1 (receive buffer full) is set by `ev_rx_byte` and cleared by `rx_rd`. If both occur in the same cycle, the set wins.
- R12: Bit 0 (transmit buffer full) is set by `tx_wr` when `busy`=0 and cleared by `ev_tx_begin`. If both occur in the same cycle, the set wins.
- R13: A CPU clear (`clr_we`=1) affects only bits 10, 7 and 6, and only where `clr_data` holds 0. Writing 1 to these bits, or writing to any other bit, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Start condition detected |
| ev_rstart | input | 1 | Repeated Start detected |
| ev_stop | input | 1 | Stop condition detected |
| ev_addr_match | input | 1 | Own device address matched |
| ev_gcall_match | input | 1 | General call address matched |
| ev_addr10_match | input | 1 | Second byte of a 10-bit address matched |
| ev_rx_byte | input | 1 | A received byte moves to the receive buffer |
| ev_tx_begin | input | 1 | Master transmission starts |
| ev_ack_done | input | 1 | Slave acknowledge slot ended |
| ack_nack | input | 1 | Sampled acknowledge level (1 = NACK) |
| ev_collision | input | 1 | Bus collision during a master operation |
| rw_in | input | 1 | Direction bit of the matched address byte |
| busy | input | 1 | Module busy; a transmit write is refused |
| tx_wr | input | 1 | CPU write to the transmit holding register |
| rx_rd | input | 1 | CPU read of the receive buffer |
| clr_we | input | 1 | CPU write-to-clear strobe |
| clr_data | input | 16 | Write data; a 0 in bit 10, 7 or 6 clears that flag |
| status | output | 16 | Status word |

## Verification
Every flag is a single register that sits directly on `status`. A wrong set/clear priority, a missing clear path or a flag stuck at a bad value therefore shows on the port one clock after the event that should have moved it. The sweep drives all 65536 combinations of the event and strobe inputs in a scrambled order from a state that keeps changing. Simultaneous set and clear events, overflow while the buffer is full, and writes while busy all occur many times. After every cycle each field is compared against a model built from the requirements.

// File: rtl/i2c_event_status.sv
module i2c_event_status (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_start,
  input  logic        ev_rstart,
  input  logic        ev_stop,
  input  logic        ev_addr_match,
  input  logic        ev_gcall_match,
  input  logic        ev_addr10_match,
  input  logic        ev_rx_byte,
  input  logic        ev_tx_begin,
  input  logic        ev_ack_done,
  input  logic        ack_nack,
  input  logic        ev_collision,
  input  logic        rw_in,
  input  logic        busy,
  input  logic        tx_wr,
  input  logic        rx_rd,
  input  logic        clr_we,
  input  logic [15:0] clr_data,
  output logic [15:0] status
);

  logic ackstat_q, txact_q, buscol_q, gcall_q, addr10_q, wcol_q, rxovf_q;
  logic dat_q, stopseen_q, startseen_q, rw_q, rxfull_q, txfull_q;

  logic any_start, wr_refused, wr_taken;
  logic clr_buscol, clr_wcol, clr_rxovf;

  assign any_start  = ev_start | ev_rstart;
  assign wr_refused = tx_wr & busy;
  assign wr_taken   = tx_wr & ~busy;
  assign clr_buscol = clr_we & ~clr_data[10];
  assign clr_wcol   = clr_we & ~clr_data[7];
  assign clr_rxovf  = clr_we & ~clr_data[6];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ackstat_q   <= 1'b0;
      txact_q     <= 1'b0;
      buscol_q    <= 1'b0;
      gcall_q     <= 1'b0;
      addr10_q    <= 1'b0;
      wcol_q      <= 1'b0;
      rxovf_q     <= 1'b0;
      dat_q       <= 1'b0;
      stopseen_q  <= 1'b0;
      startseen_q <= 1'b0;
      rw_q        <= 1'b0;
      rxfull_q    <= 1'b0;
      txfull_q    <= 1'b0;
    end else begin
      if (ev_ack_done) ackstat_q <= ack_nack;

      if (ev_tx_begin)      txact_q <= 1'b1;
      else if (ev_ack_done) txact_q <= 1'b0;

      if (ev_collision)    buscol_q <= 1'b1;
      else if (clr_buscol) buscol_q <= 1'b0;

      if (ev_gcall_match) gcall_q <= 1'b1;
      else if (ev_stop)   gcall_q <= 1'b0;

      if (ev_addr10_match) addr10_q <= 1'b1;
      else if (ev_stop)    addr10_q <= 1'b0;

      if (wr_refused)    wcol_q <= 1'b1;
      else if (clr_wcol) wcol_q <= 1'b0;

      if (ev_rx_byte && rxfull_q) rxovf_q <= 1'b1;
      else if (clr_rxovf)         rxovf_q <= 1'b0;

      if (ev_addr_match)   dat_q <= 1'b0;
      else if (ev_rx_byte) dat_q <= 1'b1;

      if (any_start) begin
        startseen_q <= 1'b1;
        stopseen_q  <= 1'b0;
      end else if (ev_stop) begin
        startseen_q <= 1'b0;
        stopseen_q  <= 1'b1;
      end

      if (ev_addr_match) rw_q <= rw_in;

      if (ev_rx_byte) rxfull_q <= 1'b1;
      else if (rx_rd) rxfull_q <= 1'b0;

      if (wr_taken)         txfull_q <= 1'b1;
      else if (ev_tx_begin) txfull_q <= 1'b0;
    end
  end

  assign status = {ackstat_q, txact_q, 3'b000, buscol_q, gcall_q, addr10_q,
                   wcol_q, rxovf_q, dat_q, stopseen_q, startseen_q,
                   rw_q, rxfull_q, txfull_q};

  AST_ACK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack_done |=> status[15] == $past(ack_nack)); // R2
  AST_TX_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_begin |=> status[14]); // R3
  AST_BUSCOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[10] && !clr_we) |=> status[10]); // R4
  AST_STOP_DROPS_GCALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !ev_gcall_match) |=> !status[9]); // R5
  AST_WCOL_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && busy) |=> status[7]); // R6
  AST_REFUSED_KEEPS_TBF: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && busy && !ev_tx_begin) |=> $stable(status[0])); // R6
  AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_byte && status[1]) |=> (status[6] && status[1])); // R7
  AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[4] && status[3])); // R9
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status[13:11] == 3'b000); // R1

endmodule

// File: tb/i2c_event_status_tb_top.sv
`timescale 1ns/1ps
module i2c_event_status_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_start = 0, ev_rstart = 0, ev_stop = 0, ev_addr_match = 0;
  logic ev_gcall_match = 0, ev_addr10_match = 0, ev_rx_byte = 0;
  logic ev_tx_begin = 0, ev_ack_done = 0, ack_nack = 0, ev_collision = 0;
  logic rw_in = 0, busy = 0, tx_wr = 0, rx_rd = 0, clr_we = 0;
  logic [15:0] clr_data = 16'hFFFF;
  logic [15:0] status;
  logic [15:0] exp_s;
  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  i2c_event_status dut_i (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_rstart(ev_rstart),
    .ev_stop(ev_stop), .ev_addr_match(ev_addr_match),
    .ev_gcall_match(ev_gcall_match), .ev_addr10_match(ev_addr10_match),
    .ev_rx_byte(ev_rx_byte), .ev_tx_begin(ev_tx_begin),
    .ev_ack_done(ev_ack_done), .ack_nack(ack_nack),
    .ev_collision(ev_collision), .rw_in(rw_in), .busy(busy), .tx_wr(tx_wr),
    .rx_rd(rx_rd), .clr_we(clr_we), .clr_data(clr_data), .status(status));

  task automatic check(input string req, input logic [15:0] mask);
    n_cmp++;
    if ((status & mask) !== (exp_s & mask)) begin
      n_bad++;
      $display("FAIL %s: status&%h actual=%h expected=%h", req, mask,
               status & mask, exp_s & mask);
    end
  endtask

  task automatic check_all(input logic wrote);
    check("R1", 16'h3800);
    check("R2", 16'h8000);
    check("R3", 16'h4000);
    check("R4", 16'h0400);
    check("R5", 16'h0300);
    check("R6", 16'h0080);
    check("R7", 16'h0040);
    check("R8", 16'h0020);
    check("R9", 16'h0018);
    check("R10", 16'h0004);
    check("R11", 16'h0002);
    check("R12", 16'h0001);
    if (wrote) check("R13", 16'hFFFF);
  endtask

  function automatic logic [15:0] next_exp(input logic [15:0] e);
    logic [15:0] n;
    logic st;
    n  = e;
    st = ev_start | ev_rstart;
    if (ev_ack_done) n[15] = ack_nack;
    if (ev_tx_begin) n[14] = 1'b1; else if (ev_ack_done) n[14] = 1'b0;
    if (ev_collision) n[10] = 1'b1; else if (clr_we && !clr_data[10]) n[10] = 1'b0;
    if (ev_gcall_match) n[9] = 1'b1; else if (ev_stop) n[9] = 1'b0;
    if (ev_addr10_match) n[8] = 1'b1; else if (ev_stop) n[8] = 1'b0;
    if (tx_wr && busy) n[7] = 1'b1; else if (clr_we && !clr_data[7]) n[7] = 1'b0;
    if (ev_rx_byte && e[1]) n[6] = 1'b1; else if (clr_we && !clr_data[6]) n[6] = 1'b0;
    if (ev_addr_match) n[5] = 1'b0; else if (ev_rx_byte) n[5] = 1'b1;
    if (st) n[4:3] = 2'b01; else if (ev_stop) n[4:3] = 2'b10;
    if (ev_addr_match) n[2] = rw_in;
    if (ev_rx_byte) n[1] = 1'b1; else if (rx_rd) n[1] = 1'b0;
    if (tx_wr && !busy) n[0] = 1'b1; else if (ev_tx_begin) n[0] = 1'b0;
    return n;
  endfunction

  initial begin
    exp_s = 16'h0000;
    repeat (3) @(negedge clk);
    check("R1", 16'hFFFF);
    rst_n = 1'b1;
    for (int i = 0; i < 65536; i++) begin
      logic [15:0] v;
      logic wrote;
      v = 16'(i * 40503 + 7);
      @(negedge clk);
      {rw_in, clr_we, rx_rd, busy, tx_wr, ev_collision, ack_nack, ev_ack_done,
       ev_tx_begin, ev_rx_byte, ev_addr10_match, ev_gcall_match,
       ev_addr_match, ev_stop, ev_rstart, ev_start} = v;
      clr_data = 16'($urandom);
      wrote = clr_we;
      exp_s = next_exp(exp_s);
      @(negedge clk);
      check_all(wrote);
      {rw_in, clr_we, rx_rd, busy, tx_wr, ev_collision, ack_nack, ev_ack_done,
       ev_tx_begin, ev_rx_byte, ev_addr10_match, ev_gcall_match,
       ev_addr_match, ev_stop, ev_rstart, ev_start} = 16'h0000;
      exp_s = next_exp(exp_s);
    end
    @(negedge clk);
    check_all(1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule